// File: doc/BRIEF.md
# Level-source interrupt pending/blocking combiner

This block gathers a vector of level-sensitive interrupt lines into a latched pending register and folds every pending line that is not blocked into one interrupt request for a parent controller. Each source line is first brought into the block's clock domain through a synchroniser. Once a source has been seen high, its pending bit stays set until software acknowledges it, even if the line has already dropped.

Software reaches the block through a small register port with a byte address, a write strobe, write data and combinational read data. The pending register sits at byte offset 0x0 and the blocking register at byte offset 0x4. A single read of the pending register returns every pending source, so a handler can service all of them from one access. It acknowledges a source by writing a one to that source's bit. A one in the blocking register hides a source from the combined request, and a zero lets it through. Bring-up clears the blocking register to zero and then writes all ones to the pending register.

Top module: `irq_cause_mask`

## Requirements
- R1: After reset the pending register (offset 0x0) and the blocking register (offset 0x4) both read 0, and `irq_o` is 0.
- R2: A source line held high before clock edge k makes its pending bit read 1 after edge k+2, which is two synchroniser flops and one register stage.
- R3: A write to offset 0x0 clears each pending bit whose write-data bit is 1 and leaves each pending bit whose write-data bit is 0 unchanged.
- R4: When a source is still high (after synchronisation) in the cycle of a clearing write, its pending bit stays 1, because setting wins over clearing.
- R5: A write to offset 0x4 stores the write data, and a read of offset 0x4 returns exactly the last value written.
- R6: `irq_o` is 1 one cycle after the register state has at least one bit that is pending and not blocked (blocking bit 0), and 0 one cycle after there is none.
- R7: Reads of any offset other than 0x0 and 0x4 return 0, and writes to them change neither register.
- R8: A pending bit stays 1 after its source drops, until it is acknowledged.
- R9: The bring-up sequence (write 0 to offset 0x4, then all ones to offset 0x0) leaves no pending bit, no blocking bit, and `irq_o` low once its sources are idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_i | input | NUM_SRC (32) | Level interrupt source lines, asynchronous |
| reg_addr_i | input | ADDR_W (4) | Byte address of the register access |
| reg_we_i | input | 1 | Write strobe, one cycle per write |
| reg_wdata_i | input | NUM_SRC (32) | Write data |
| reg_rdata_o | output | NUM_SRC (32) | Combinational read data for `reg_addr_i` |
| irq_o | output | 1 | Registered combined interrupt request |

## Verification
A pending bit that is lost or kept by mistake shows up in the very next read of offset 0x0, and one cycle after the register edge it shows up as a wrong level on `irq_o`. A corrupted blocking bit is visible straight away on a read of offset 0x4, and it makes `irq_o` wrong one cycle later whenever that source is pending. The bench therefore reads both registers after every stimulus and checks `irq_o` exactly one edge after each register change. It also drives a source that is still held high while that source is being acknowledged, and it writes to unmapped offsets while sources are pending.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

    localparam logic [31:0] OFS_PEND  = 32'h0;
    localparam logic [31:0] OFS_BLOCK = 32'h4;

    typedef enum logic [1:0] {
        SEL_PEND  = 2'd0,
        SEL_BLOCK = 2'd1,
        SEL_NONE  = 2'd2
    } reg_sel_e;

    function automatic reg_sel_e decode_addr(input logic [31:0] addr);
        if (addr == OFS_PEND)       return SEL_PEND;
        else if (addr == OFS_BLOCK) return SEL_BLOCK;
        else                        return SEL_NONE;
    endfunction

endpackage

// File: rtl/irq_agg_sync.sv
module irq_agg_sync #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din_i,
    output logic [WIDTH-1:0] dout_o
);
    logic [WIDTH-1:0] stage_d [STAGES];
    logic [WIDTH-1:0] stage_q [STAGES];

    always_comb begin
        stage_d[0] = din_i;
        for (int i = 1; i < STAGES; i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[g] <= '0;
                else        stage_q[g] <= stage_d[g];
            end
        end
    endgenerate

    assign dout_o = stage_q[STAGES-1];
endmodule

// File: rtl/irq_agg_regs.sv
module irq_agg_regs
    import irq_agg_pkg::*;
#(
    parameter int NUM_SRC = 32,
    parameter int ADDR_W  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] set_i,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic               we_i,
    input  logic [NUM_SRC-1:0] wdata_i,
    output logic [NUM_SRC-1:0] rdata_o,
    output logic [NUM_SRC-1:0] pend_o,
    output logic [NUM_SRC-1:0] block_o
);
    typedef struct packed {
        logic [NUM_SRC-1:0] pend;
        logic [NUM_SRC-1:0] block;
    } regs_t;

    regs_t    regs_d, regs_q;
    reg_sel_e sel;
    logic [NUM_SRC-1:0] ack_bits;

    always_comb begin
        sel      = decode_addr(32'(addr_i));
        ack_bits = (we_i && sel == SEL_PEND) ? wdata_i : '0;
        regs_d   = regs_q;
        // clear first, then set: a live source wins over an acknowledge
        regs_d.pend = (regs_q.pend & ~ack_bits) | set_i;
        if (we_i && sel == SEL_BLOCK) begin
            regs_d.block = wdata_i;
        end
        unique case (sel)
            SEL_PEND:  rdata_o = regs_q.pend;
            SEL_BLOCK: rdata_o = regs_q.block;
            default:   rdata_o = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign pend_o  = regs_q.pend;
    assign block_o = regs_q.block;
endmodule

// File: rtl/irq_agg_out.sv
module irq_agg_out #(
    parameter int NUM_SRC = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] pend_i,
    input  logic [NUM_SRC-1:0] block_i,
    output logic               irq_o
);
    logic req_d, req_q;

    always_comb begin
        req_d = |(pend_i & ~block_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) req_q <= 1'b0;
        else        req_q <= req_d;
    end

    assign irq_o = req_q;
endmodule

// File: rtl/irq_cause_mask.sv
module irq_cause_mask #(
    parameter int NUM_SRC     = 32,
    parameter int ADDR_W      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic [ADDR_W-1:0]  reg_addr_i,
    input  logic               reg_we_i,
    input  logic [NUM_SRC-1:0] reg_wdata_i,
    output logic [NUM_SRC-1:0] reg_rdata_o,
    output logic               irq_o
);
    logic [NUM_SRC-1:0] src_sync_w;
    logic [NUM_SRC-1:0] pend_w;
    logic [NUM_SRC-1:0] block_w;

    irq_agg_sync #(.WIDTH(NUM_SRC), .STAGES(SYNC_STAGES)) sync_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .din_i  (src_i),
        .dout_o (src_sync_w)
    );

    irq_agg_regs #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) regs_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (src_sync_w),
        .addr_i  (reg_addr_i),
        .we_i    (reg_we_i),
        .wdata_i (reg_wdata_i),
        .rdata_o (reg_rdata_o),
        .pend_o  (pend_w),
        .block_o (block_w)
    );

    irq_agg_out #(.NUM_SRC(NUM_SRC)) out_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .pend_i  (pend_w),
        .block_i (block_w),
        .irq_o   (irq_o)
    );
endmodule

// File: rtl/irq_cause_mask_chk.sv
module irq_cause_mask_chk
    import irq_agg_pkg::*;
#(
    parameter int NUM_SRC = 32,
    parameter int ADDR_W  = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic [ADDR_W-1:0]  reg_addr_i,
    input logic               reg_we_i,
    input logic [NUM_SRC-1:0] reg_wdata_i,
    input logic [NUM_SRC-1:0] reg_rdata_o,
    input logic               irq_o,
    input logic [NUM_SRC-1:0] pend_q,
    input logic [NUM_SRC-1:0] block_q,
    input logic [NUM_SRC-1:0] sync_q
);
    logic pend_wr, block_wr, unmapped;
    assign unmapped = decode_addr(32'(reg_addr_i)) == SEL_NONE;
    assign pend_wr  = reg_we_i && decode_addr(32'(reg_addr_i)) == SEL_PEND;
    assign block_wr = reg_we_i && decode_addr(32'(reg_addr_i)) == SEL_BLOCK;

    assert_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (pend_q & $past(sync_q)) == $past(sync_q));

    assert_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pend_wr |=> (pend_q & $past(reg_wdata_i) & ~$past(sync_q)) == '0);

    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !pend_wr |=> (pend_q & $past(pend_q)) == $past(pend_q));

    assert_block_wr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        block_wr |=> block_q == $past(reg_wdata_i));

    assert_block_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !block_wr |=> $stable(block_q));

    assert_unmapped_rd_R7: assert property (@(posedge clk) disable iff (!rst_n)
        unmapped |-> reg_rdata_o == '0);

    assert_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> irq_o == $past(|(pend_q & ~block_q)));
endmodule

bind irq_cause_mask irq_cause_mask_chk #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_addr_i  (reg_addr_i),
    .reg_we_i    (reg_we_i),
    .reg_wdata_i (reg_wdata_i),
    .reg_rdata_o (reg_rdata_o),
    .irq_o       (irq_o),
    .pend_q      (pend_w),
    .block_q     (block_w),
    .sync_q      (src_sync_w)
);

// File: tb/irq_cause_mask_tb.sv
module irq_cause_mask_tb_top;
    localparam int N  = 32;
    localparam int AW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  src = '0;
    logic [AW-1:0] addr = '0;
    logic          we = 1'b0;
    logic [N-1:0]  wdata = '0;
    logic [N-1:0]  rdata;
    logic          irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    irq_cause_mask #(.NUM_SRC(N), .ADDR_W(AW)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .src_i       (src),
        .reg_addr_i  (addr),
        .reg_we_i    (we),
        .reg_wdata_i (wdata),
        .reg_rdata_o (rdata),
        .irq_o       (irq)
    );

    task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [N-1:0] v);
        addr = a;
        #1;
        v = rdata;
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [N-1:0] d);
        @(negedge clk);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0; wdata = '0;
    endtask

    task automatic pulse_src(input logic [N-1:0] s);
        @(negedge clk);
        src = s;
        @(negedge clk);
        src = '0;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [N-1:0] v;
        @(negedge clk);
        rd(4'h0, v); chk("R1 pending", v, '0);
        rd(4'h4, v); chk("R1 blocking", v, '0);
        chk("R1 irq", N'(irq), '0);
    endtask

    task automatic t_capture;
        logic [N-1:0] v;
        @(negedge clk);
        src = 32'h0000_0005;
        repeat (2) @(negedge clk);
        rd(4'h0, v); chk("R2 not yet after two edges", v, '0);
        @(negedge clk);
        rd(4'h0, v); chk("R2 set after three edges", v, 32'h5);
        src = '0;
        repeat (4) @(negedge clk);
        rd(4'h0, v); chk("R8 held after source drop", v, 32'h5);
        chk("R6 irq high unblocked", N'(irq), 1);
    endtask

    task automatic t_ack;
        logic [N-1:0] v;
        wr(4'h0, 32'h1);
        rd(4'h0, v); chk("R3 one clears bit0", v, 32'h4);
        wr(4'h0, 32'h0);
        rd(4'h0, v); chk("R3 zero leaves bits", v, 32'h4);
        wr(4'h0, 32'h4);
        rd(4'h0, v); chk("R3 last bit cleared", v, '0);
        chk("R6 irq still high one cycle", N'(irq), 1);
        @(negedge clk);
        chk("R6 irq low after clear", N'(irq), 0);
    endtask

    task automatic t_set_wins;
        logic [N-1:0] v;
        @(negedge clk);
        src = 32'h0000_0080;
        repeat (4) @(negedge clk);
        wr(4'h0, 32'h80);
        rd(4'h0, v); chk("R4 set wins over ack", v, 32'h80);
        src = '0;
        repeat (3) @(negedge clk);
        wr(4'h0, 32'h80);
        rd(4'h0, v); chk("R4 ack after drop clears", v, '0);
        @(negedge clk);
    endtask

    task automatic t_block;
        logic [N-1:0] v;
        wr(4'h4, 32'hA5A5_0F0F);
        rd(4'h4, v); chk("R5 readback", v, 32'hA5A5_0F0F);
        wr(4'h4, 32'h0000_0001);
        rd(4'h4, v); chk("R5 readback second", v, 32'h1);
        pulse_src(32'h1);
        rd(4'h0, v); chk("R8 blocked source still pending", v, 32'h1);
        @(negedge clk);
        chk("R6 blocked source gives no irq", N'(irq), 0);
        wr(4'h4, 32'h0);
        chk("R6 irq low in unblock cycle", N'(irq), 0);
        @(negedge clk);
        chk("R6 irq high one cycle after unblock", N'(irq), 1);
        wr(4'h0, 32'h1);
        @(negedge clk);
    endtask

    task automatic t_unmapped;
        logic [N-1:0] v;
        wr(4'h4, 32'h0000_00F0);
        pulse_src(32'h0000_0100);
        wr(4'h8, 32'hFFFF_FFFF);
        rd(4'h8, v); chk("R7 read 0x8 zero", v, '0);
        rd(4'hC, v); chk("R7 read 0xC zero", v, '0);
        rd(4'h1, v); chk("R7 read 0x1 zero", v, '0);
        rd(4'h4, v); chk("R7 blocking untouched", v, 32'hF0);
        rd(4'h0, v); chk("R7 pending untouched", v, 32'h100);
    endtask

    task automatic t_init;
        logic [N-1:0] v;
        pulse_src(32'hFFFF_0000);
        wr(4'h0, 32'h0);
        rd(4'h0, v); chk("R9 pending before init", v, 32'hFFFF_0100);
        wr(4'h4, 32'h0);
        wr(4'h0, 32'hFFFF_FFFF);
        rd(4'h0, v); chk("R9 pending cleared", v, '0);
        rd(4'h4, v); chk("R9 blocking cleared", v, '0);
        @(negedge clk);
        chk("R9 irq low", N'(irq), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_capture();
        t_ack();
        t_set_wins();
        t_block();
        t_unmapped();
        t_init();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule